// File: doc/BRIEF.md
# Multi-Block DMA Channel Sequencer

A single DMA channel that copies data item by item and groups the items into blocks. Software programs a starting source address, destination address, control word and next-descriptor pointer, picks how each block boundary is handled, and sets the channel running. Each item is read from the source with the source width and then written to the destination with the destination width. The two addresses then step according to their own increment modes.

At the end of a block, each of the three fields (source address, destination address, control word) is handled on its own terms. It is either restored to its programmed starting value or taken from a four-word descriptor that the channel fetches from memory. Setting only some of the reload bits gives mixed modes, such as a fixed source buffer that is reused while the destinations come from a linked chain. A block-complete flag can be raised at each boundary. While that flag is set and more blocks follow, the channel holds. When the last block ends, the channel raises a transfer-complete flag and clears its own enable.

Software finds an idle channel by checking that the enable output is low. Writing 0 to the enable register aborts the channel at the next item boundary.

Top module: `dma_seq`

## Requirements
- R1: After reset `ch_en`, `stat_block`, `stat_xfer` and `irq` are 0, and `desc_req`, `mem_rd_req` and `mem_wr_en` are low.
- R2: Register addresses are 0 = start source address, 1 = start destination address, 2 = start next-descriptor pointer, 3 = start control word, 4 = config, 5 = enable, 6 = status clear. Writing 1 in bit 0 of the enable register while idle starts the channel from the programmed start values, and `ch_en` is 1 from the next cycle.
- R3: Each item is one source read (`mem_rd_req` held until `mem_rd_valid`), followed in the next cycle by a one-cycle write of the same data to the destination. No read is requested while `ch_en` is 0.
- R4: The control word holds the item count in bits 11:0, the source width in bits 13:12, the destination width in bits 15:14, the source step mode in bits 17:16, the destination step mode in bits 19:18, the block interrupt enable in bit 20, the read master in bit 21, the write master in bit 22 and the kind in bits 24:23. Width code 0, 1 and 2 mean 1, 2 and 4 bytes. Step mode 0 adds the width, mode 1 subtracts it, and modes 2 and 3 leave the address unchanged.
- R5: A block moves exactly as many items as its count field holds. A count of 0 moves none.
- R6: Config bit 0, bit 1 and bit 2 make the source address, destination address and control word reload their start values at each block boundary. With all three set, blocks repeat.
- R7: Every field whose reload bit is clear comes from a descriptor of four words read at pointer+0, +4, +8 and +12. The words are, in order, source, destination, next pointer and control. When at least one field is not reloaded, a block that ends with a zero next pointer is the last one.
- R8: In mixed mode with only source reload set, every block reads from the start source address while the destinations follow the descriptor chain.
- R9: `stat_block` is set at a block boundary only when control bit 20 is 1 and config bit 3 (block mask) is 1. It stays set until software writes 1 to bit 0 of the clear register.
- R10: After setting `stat_block` with further blocks pending, the channel starts no item until `stat_block` has been cleared.
- R11: At the end of the last block `stat_xfer` is set and `ch_en` drops in the same cycle. `stat_xfer` stays set until software writes 1 to bit 1 of the clear register. `irq` is high whenever either status flag is set.
- R12: Writing 0 to the enable register stops the channel at the next item boundary without setting `stat_xfer`. No later item is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| ch_en | output | 1 | Channel active |
| stat_block | output | 1 | Sticky block-complete flag |
| stat_xfer | output | 1 | Sticky transfer-complete flag |
| irq | output | 1 | Interrupt, OR of both flags |
| desc_req | output | 1 | Descriptor word request |
| desc_addr | output | 32 | Descriptor word byte address |
| desc_valid | input | 1 | Descriptor word returned |
| desc_data | input | 32 | Descriptor word |
| mem_rd_req | output | 1 | Source read request |
| mem_rd_addr | output | 32 | Source byte address |
| mem_rd_size | output | 2 | Source width code |
| mem_rd_master | output | 1 | Source master select |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data |
| mem_wr_en | output | 1 | Destination write strobe |
| mem_wr_addr | output | 32 | Destination byte address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_size | output | 2 | Destination width code |
| mem_wr_master | output | 1 | Destination master select |
| xfer_kind | output | 2 | Transfer kind / flow-control field of the active control word |

## Verification
The sequencer is tried with several patterns:
- Single blocks with every width and step mode, which separate increment, decrement and fixed addressing and show that source and destination widths are independent.
- Random linked chains with random reload subsets, which check, field by field, that each reload bit selects between the start value and the descriptor word.
- A fully reloading run that is ended by clearing the reload bits, which tells the reload path apart from the linked path and from the rule that a null pointer ends the transfer.
- A mixed source-reload chain, a zero-count block, an enabled interrupt with the mask clear, and an abort in the middle of a block, which show the stall, the mask gate and the item-boundary stop.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned LEN_W      = 12;
    localparam int unsigned CTL_W      = LEN_W + 13;
    localparam int unsigned RADDR_W    = 3;
    localparam int unsigned DESC_WORDS = 4;
    localparam int unsigned IDX_W      = $clog2(DESC_WORDS);

    localparam logic [RADDR_W-1:0] RA_SRC = 3'd0;
    localparam logic [RADDR_W-1:0] RA_DST = 3'd1;
    localparam logic [RADDR_W-1:0] RA_LLP = 3'd2;
    localparam logic [RADDR_W-1:0] RA_CTL = 3'd3;
    localparam logic [RADDR_W-1:0] RA_CFG = 3'd4;
    localparam logic [RADDR_W-1:0] RA_EN  = 3'd5;
    localparam logic [RADDR_W-1:0] RA_CLR = 3'd6;

    // control word, MSB first
    typedef struct packed {
        logic [1:0]       kind;
        logic             wr_mst;
        logic             rd_mst;
        logic             int_en;
        logic [1:0]       dst_mode;
        logic [1:0]       src_mode;
        logic [1:0]       dst_w;
        logic [1:0]       src_w;
        logic [LEN_W-1:0] len;
    } ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_BEND  = 3'd3,
        ST_FETCH = 3'd4,
        ST_STALL = 3'd5
    } state_e;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    width_i,
    input  logic [1:0]    mode_i,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] ONE_B  = AW'(1);
    localparam logic [AW-1:0] TWO_B  = AW'(2);
    localparam logic [AW-1:0] FOUR_B = AW'(4);

    logic [AW-1:0] bytes;

    always_comb begin
        case (width_i)
            2'd0:    bytes = ONE_B;
            2'd1:    bytes = TWO_B;
            default: bytes = FOUR_B;
        endcase
        case (mode_i)
            2'd0:    addr_o = addr_i + bytes;
            2'd1:    addr_o = addr_i - bytes;
            default: addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [AW-1:0]      src_init,
    output logic [AW-1:0]      dst_init,
    output logic [AW-1:0]      llp_init,
    output ctl_t               ctl_init,
    output logic               rel_src,
    output logic               rel_dst,
    output logic               rel_ctl,
    output logic               blk_mask
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] llp;
        ctl_t          ctl;
        logic [3:0]    cfg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_addr)
                RA_SRC:  r_d.src = reg_wdata[AW-1:0];
                RA_DST:  r_d.dst = reg_wdata[AW-1:0];
                RA_LLP:  r_d.llp = reg_wdata[AW-1:0];
                RA_CTL:  r_d.ctl = ctl_t'(reg_wdata[CTL_W-1:0]);
                RA_CFG:  r_d.cfg = reg_wdata[3:0];
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign src_init = r_q.src;
    assign dst_init = r_q.dst;
    assign llp_init = r_q.llp;
    assign ctl_init = r_q.ctl;
    assign rel_src  = r_q.cfg[0];
    assign rel_dst  = r_q.cfg[1];
    assign rel_ctl  = r_q.cfg[2];
    assign blk_mask = r_q.cfg[3];
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic               ch_en,
    output logic               stat_block,
    output logic               stat_xfer,
    output logic               irq,
    output logic               desc_req,
    output logic [AW-1:0]      desc_addr,
    input  logic               desc_valid,
    input  logic [DW-1:0]      desc_data,
    output logic               mem_rd_req,
    output logic [AW-1:0]      mem_rd_addr,
    output logic [1:0]         mem_rd_size,
    output logic               mem_rd_master,
    input  logic               mem_rd_valid,
    input  logic [DW-1:0]      mem_rd_data,
    output logic               mem_wr_en,
    output logic [AW-1:0]      mem_wr_addr,
    output logic [DW-1:0]      mem_wr_data,
    output logic [1:0]         mem_wr_size,
    output logic               mem_wr_master,
    output logic [1:0]         xfer_kind
);
    localparam int unsigned     N_SIDES  = 2;
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(DESC_WORDS - 1);

    typedef struct packed {
        state_e           st;
        logic             en;
        logic             st_blk;
        logic             st_xfer;
        logic             stall_pend;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [AW-1:0]    llp;
        ctl_t             ctl;
        logic [LEN_W-1:0] cnt;
        logic [DW-1:0]    data;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    n_src;
        logic [AW-1:0]    n_dst;
        logic [AW-1:0]    n_llp;
    } core_t;

    core_t c_d, c_q;

    logic [AW-1:0] src_init, dst_init, llp_init;
    ctl_t          ctl_init;
    logic          rel_src, rel_dst, rel_ctl, blk_mask;
    logic          linked_any;

    dma_seq_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .src_init (src_init),
        .dst_init (dst_init),
        .llp_init (llp_init),
        .ctl_init (ctl_init),
        .rel_src  (rel_src),
        .rel_dst  (rel_dst),
        .rel_ctl  (rel_ctl),
        .blk_mask (blk_mask)
    );

    // one address stepper per side: index 0 = source, 1 = destination
    logic [AW-1:0] side_cur [N_SIDES];
    logic [1:0]    side_w   [N_SIDES];
    logic [1:0]    side_m   [N_SIDES];
    logic [AW-1:0] side_nxt [N_SIDES];

    always_comb begin
        side_cur[0] = c_q.src;
        side_w[0]   = c_q.ctl.src_w;
        side_m[0]   = c_q.ctl.src_mode;
        side_cur[1] = c_q.dst;
        side_w[1]   = c_q.ctl.dst_w;
        side_m[1]   = c_q.ctl.dst_mode;
    end

    for (genvar g = 0; g < N_SIDES; g++) begin : g_step
        dma_addr_step #(.AW(AW)) u_step (
            .addr_i (side_cur[g]),
            .width_i(side_w[g]),
            .mode_i (side_m[g]),
            .addr_o (side_nxt[g])
        );
    end

    assign linked_any = !(rel_src && rel_dst && rel_ctl);

    logic wr_en_reg, wr_clr_reg;
    logic blk_raise, blk_last;
    ctl_t fetched_ctl;

    always_comb begin
        wr_en_reg   = reg_we && (reg_addr == RA_EN);
        wr_clr_reg  = reg_we && (reg_addr == RA_CLR);
        blk_raise   = c_q.ctl.int_en && blk_mask;
        blk_last    = linked_any && (c_q.llp == '0);
        fetched_ctl = rel_ctl ? ctl_init : ctl_t'(desc_data[CTL_W-1:0]);

        c_d        = c_q;
        desc_req   = 1'b0;
        mem_rd_req = 1'b0;
        mem_wr_en  = 1'b0;

        // software side: status clear and abort
        if (wr_clr_reg) begin
            if (reg_wdata[0]) c_d.st_blk  = 1'b0;
            if (reg_wdata[1]) c_d.st_xfer = 1'b0;
        end
        if (wr_en_reg && !reg_wdata[0]) c_d.en = 1'b0;

        case (c_q.st)
            ST_IDLE: begin
                if (wr_en_reg && reg_wdata[0]) begin
                    c_d.en  = 1'b1;
                    c_d.src = src_init;
                    c_d.dst = dst_init;
                    c_d.llp = llp_init;
                    c_d.ctl = ctl_init;
                    c_d.cnt = ctl_init.len;
                    c_d.st  = ST_READ;
                end
            end
            ST_READ: begin
                if (!c_q.en) begin
                    c_d.st = ST_IDLE;
                end else if (c_q.cnt == '0) begin
                    c_d.st = ST_BEND;
                end else begin
                    mem_rd_req = 1'b1;
                    if (mem_rd_valid) begin
                        c_d.data = mem_rd_data;
                        c_d.st   = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                mem_wr_en = 1'b1;
                c_d.src   = side_nxt[0];
                c_d.dst   = side_nxt[1];
                c_d.cnt   = c_q.cnt - LEN_ONE;
                c_d.st    = ST_READ;
            end
            ST_BEND: begin
                if (blk_raise) c_d.st_blk = 1'b1;
                if (blk_last) begin
                    c_d.st_xfer = 1'b1;
                    c_d.en      = 1'b0;
                    c_d.st      = ST_IDLE;
                end else if (linked_any) begin
                    c_d.stall_pend = blk_raise;
                    c_d.idx        = '0;
                    c_d.st         = ST_FETCH;
                end else begin
                    c_d.src = src_init;
                    c_d.dst = dst_init;
                    c_d.ctl = ctl_init;
                    c_d.cnt = ctl_init.len;
                    c_d.st  = blk_raise ? ST_STALL : ST_READ;
                end
            end
            ST_FETCH: begin
                desc_req = 1'b1;
                if (desc_valid) begin
                    c_d.idx = c_q.idx + IDX_ONE;
                    case (c_q.idx)
                        2'd0:    c_d.n_src = desc_data[AW-1:0];
                        2'd1:    c_d.n_dst = desc_data[AW-1:0];
                        2'd2:    c_d.n_llp = desc_data[AW-1:0];
                        default: c_d.n_llp = c_q.n_llp;
                    endcase
                    if (c_q.idx == IDX_END) begin
                        c_d.src = rel_src ? src_init : c_q.n_src;
                        c_d.dst = rel_dst ? dst_init : c_q.n_dst;
                        c_d.llp = c_q.n_llp;
                        c_d.ctl = fetched_ctl;
                        c_d.cnt = fetched_ctl.len;
                        c_d.st  = c_q.stall_pend ? ST_STALL : ST_READ;
                    end
                end
            end
            ST_STALL: begin
                if (!c_q.en)          c_d.st = ST_IDLE;
                else if (!c_q.st_blk) c_d.st = ST_READ;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ch_en         = c_q.en;
    assign stat_block    = c_q.st_blk;
    assign stat_xfer     = c_q.st_xfer;
    assign irq           = c_q.st_blk | c_q.st_xfer;
    assign desc_addr     = c_q.llp + AW'({c_q.idx, 2'b00});
    assign mem_rd_addr   = c_q.src;
    assign mem_rd_size   = c_q.ctl.src_w;
    assign mem_rd_master = c_q.ctl.rd_mst;
    assign mem_wr_addr   = c_q.dst;
    assign mem_wr_data   = c_q.data;
    assign mem_wr_size   = c_q.ctl.dst_w;
    assign mem_wr_master = c_q.ctl.wr_mst;
    assign xfer_kind     = c_q.ctl.kind;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
    import dma_seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [RADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               ch_en,
    input logic               stat_block,
    input logic               stat_xfer,
    input logic               desc_req,
    input logic               mem_rd_req,
    input logic               mem_rd_valid,
    input logic [ADDR_W-1:0]  mem_rd_addr,
    input logic               mem_wr_en
);
    p_rd_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |-> !mem_rd_req);

    p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_req && mem_rd_valid));

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (!mem_rd_req || $stable(mem_rd_addr)));

    p_fetch_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_req && (mem_rd_req || mem_wr_en)));

    p_done_disables_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_xfer) |-> !ch_en);

    p_xfer_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_xfer) |-> $past(reg_we && reg_addr == RA_CLR && reg_wdata[1]));

    p_blk_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_block) |-> $past(reg_we && reg_addr == RA_CLR && reg_wdata[0]));
endmodule

bind dma_seq dma_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .ch_en       (ch_en),
    .stat_block  (stat_block),
    .stat_xfer   (stat_xfer),
    .desc_req    (desc_req),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_en   (mem_wr_en)
);

// File: tb/sim_dma_seq.sv
module sim_dma_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        ch_en, stat_block, stat_xfer, irq;
    logic        desc_req, desc_valid;
    logic [31:0] desc_addr, desc_data;
    logic        mem_rd_req, mem_rd_master, mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_addr, mem_rd_data;
    logic [1:0]  mem_rd_size, mem_wr_size, xfer_kind;
    logic        mem_wr_en, mem_wr_master;
    logic [31:0] mem_wr_addr, mem_wr_data;

    logic [31:0] dmem [64];

    dma_seq u0 (.*);

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    function automatic logic [31:0] rd_pat(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h5A00_0000;
    endfunction

    assign desc_valid  = desc_req;
    assign desc_data   = dmem[desc_addr[7:2]];
    assign mem_rd_data = rd_pat(mem_rd_addr);

    always @(negedge clk) mem_rd_valid <= ($urandom_range(0, 3) != 0);

    // write log
    logic [31:0] wl_addr [1024];
    logic [31:0] wl_data [1024];
    logic [1:0]  wl_size [1024];
    logic        wl_mst  [1024];
    int wl_n = 0;
    always @(negedge clk) begin
        if (rst_n && mem_wr_en && wl_n < 1024) begin
            wl_addr[wl_n] = mem_wr_addr;
            wl_data[wl_n] = mem_wr_data;
            wl_size[wl_n] = mem_wr_size;
            wl_mst[wl_n]  = mem_wr_master;
            wl_n = wl_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // control word: len 11:0, sw 13:12, dw 15:14, smode 17:16, dmode 19:18, ie 20, rm 21, wm 22
    function automatic logic [31:0] mkctl(input int len, input logic [1:0] sw, input logic [1:0] dw,
                                          input logic [1:0] sm, input logic [1:0] dm,
                                          input logic ie, input logic wm);
        return {9'd0, wm, 1'b0, ie, dm, sm, dw, sw, 12'(len)};
    endfunction

    function automatic logic [31:0] stepa(input logic [31:0] a, input logic [1:0] w,
                                          input logic [1:0] m, input int k);
        int b;
        b = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
        if (m == 2'd0) return a + 32'(k * b);
        if (m == 2'd1) return a - 32'(k * b);
        return a;
    endfunction

    // expected block list
    logic [31:0] eb_src [8];
    logic [31:0] eb_dst [8];
    logic [31:0] eb_ctl [8];
    int nb, exp_irq, exp_wr;

    task automatic plan_chain(input logic [3:0] cfg, input logic [31:0] s0, input logic [31:0] d0,
                              input logic [31:0] c0, input logic [31:0] l0);
        logic [31:0] s, d, c, l;
        bit linked;
        s = s0; d = d0; c = c0; l = l0;
        nb = 0; exp_irq = 0; exp_wr = 0;
        linked = !(cfg[0] && cfg[1] && cfg[2]);
        for (int b = 0; b < 8; b++) begin
            eb_src[nb] = s; eb_dst[nb] = d; eb_ctl[nb] = c; nb++;
            exp_wr += int'(c[11:0]);
            if (c[20] && cfg[3]) exp_irq++;
            if (linked && l == 0) break;
            if (!linked) begin
                s = s0; d = d0; c = c0;
            end else begin
                s = cfg[0] ? s0 : dmem[l[7:2]];
                d = cfg[1] ? d0 : dmem[l[7:2] + 6'd1];
                c = cfg[2] ? c0 : {7'd0, dmem[l[7:2] + 6'd3][24:0]};
                l = dmem[l[7:2] + 6'd2];
            end
        end
    endtask

    task automatic compare_log(input string tag, input int base);
        int i, bad;
        logic [31:0] ea, ed;
        i = base; bad = 0;
        chk(wl_n - base == exp_wr, tag, "write count", 32'(wl_n - base), 32'(exp_wr));
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < int'(eb_ctl[b][11:0]); k++) begin
                ea = stepa(eb_dst[b], eb_ctl[b][15:14], eb_ctl[b][19:18], k);
                ed = rd_pat(stepa(eb_src[b], eb_ctl[b][13:12], eb_ctl[b][17:16], k));
                if (i < wl_n && bad == 0) begin
                    if (wl_addr[i] !== ea) begin bad = 1; chk(0, tag, "write address", wl_addr[i], ea); end
                    else if (wl_data[i] !== ed) begin bad = 1; chk(0, tag, "write data", wl_data[i], ed); end
                    else if (wl_size[i] !== eb_ctl[b][15:14]) begin
                        bad = 1; chk(0, tag, "write size", 32'(wl_size[i]), 32'(eb_ctl[b][15:14]));
                    end else if (wl_mst[i] !== eb_ctl[b][22]) begin
                        bad = 1; chk(0, tag, "write master", 32'(wl_mst[i]), 32'(eb_ctl[b][22]));
                    end
                end
                i++;
            end
        end
        if (bad == 0) chk(1, tag, "write contents", 0, 0);
    endtask

    task automatic run_xfer(output int nirq);
        int guard, c0;
        nirq = 0; guard = 0;
        reg_wr(3'd5, 32'd1);
        chk(ch_en === 1'b1, "R2", "ch_en after enable", 32'(ch_en), 1);
        while ((ch_en || stat_block) && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (stat_block) begin
                nirq++;
                if (ch_en) begin
                    c0 = wl_n;
                    repeat (20) @(negedge clk);
                    chk(wl_n == c0, "R10", "writes during stall", 32'(wl_n), 32'(c0));
                end
                reg_wr(3'd6, 32'd1);
            end
        end
    endtask

    task automatic do_case(input string tag, input logic [3:0] cfg, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] l, input logic [31:0] c,
                           output int base);
        int nirq;
        reg_wr(3'd6, 32'd3);
        reg_wr(3'd0, s); reg_wr(3'd1, d); reg_wr(3'd2, l); reg_wr(3'd3, c);
        reg_wr(3'd4, {28'd0, cfg});
        plan_chain(cfg, s, d, c, l);
        base = wl_n;
        run_xfer(nirq);
        compare_log(tag, base);
        chk(nirq == exp_irq, "R9", "block interrupt count", 32'(nirq), 32'(exp_irq));
        chk(stat_xfer === 1'b1 && ch_en === 1'b0, "R11", "done flag / enable",
            {30'd0, stat_xfer, ch_en}, 32'h2);
        chk(irq === 1'b1, "R11", "irq with done flag", 32'(irq), 1);
        reg_wr(3'd6, 32'd2);
        chk(stat_xfer === 1'b0 && irq === 1'b0, "R11", "flags after clear",
            {30'd0, stat_xfer, irq}, 0);
    endtask

    initial begin
        int base, c0, nirq;
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk({ch_en, stat_block, stat_xfer, irq} === 4'b0, "R1", "status after reset",
            {28'd0, ch_en, stat_block, stat_xfer, irq}, 0);
        chk({desc_req, mem_rd_req, mem_wr_en} === 3'b0, "R1", "requests after reset",
            {29'd0, desc_req, mem_rd_req, mem_wr_en}, 0);

        // R2/R3/R4: single block, 32-bit incrementing
        do_case("R3", 4'h0, 32'h100, 32'h200, 32'h0, mkctl(4, 2, 2, 0, 0, 0, 1), base);

        // R4: decrementing 16-bit source, fixed 8-bit destination
        do_case("R4", 4'h0, 32'h400, 32'h500, 32'h0, mkctl(3, 1, 0, 1, 2, 0, 0), base);
        chk(wl_addr[base + 1] === 32'h500, "R4", "fixed dest address", wl_addr[base + 1], 32'h500);
        chk(wl_data[base + 2] === rd_pat(32'h3FC), "R4", "decrement source data",
            wl_data[base + 2], rd_pat(32'h3FC));

        // R5: zero count
        do_case("R5", 4'h0, 32'h600, 32'h700, 32'h0, mkctl(0, 2, 2, 0, 0, 0, 0), base);
        chk(wl_n == base, "R5", "no writes for zero count", 32'(wl_n - base), 0);

        // R9: interrupt enabled in control word but masked
        do_case("R9", 4'h0, 32'h800, 32'h900, 32'h0, mkctl(2, 2, 2, 0, 0, 1, 0), base);

        // R7/R8: mixed mode, source reloads, destinations linked
        dmem[4] = 32'hDEAD_0000; dmem[5] = 32'hA00; dmem[6] = 32'h20; dmem[7] = mkctl(2, 2, 2, 0, 0, 1, 0);
        dmem[8] = 32'hBEEF_0000; dmem[9] = 32'hB00; dmem[10] = 32'h0; dmem[11] = mkctl(3, 2, 1, 0, 0, 0, 1);
        do_case("R8", 4'b1001, 32'h300, 32'hC00, 32'h10, mkctl(2, 2, 2, 0, 0, 1, 0), base);
        chk(wl_data[base + 2] === rd_pat(32'h300), "R8", "second block reads start source",
            wl_data[base + 2], rd_pat(32'h300));
        chk(wl_addr[base + 4] === 32'hB00, "R8", "third block dest from list",
            wl_addr[base + 4], 32'hB00);

        // R6/R10: full reload, ended by clearing reload bits
        reg_wr(3'd6, 32'd3);
        reg_wr(3'd0, 32'h1000); reg_wr(3'd1, 32'h2000); reg_wr(3'd2, 32'h0);
        reg_wr(3'd3, mkctl(3, 2, 2, 0, 0, 1, 0));
        reg_wr(3'd4, 32'hF);
        base = wl_n;
        reg_wr(3'd5, 32'd1);
        for (int i = 0; i < 2000 && !stat_block; i++) @(negedge clk);
        chk(wl_n - base == 3 && ch_en, "R6", "first reload block", 32'(wl_n - base), 3);
        c0 = wl_n;
        repeat (20) @(negedge clk);
        chk(wl_n == c0, "R10", "stall holds", 32'(wl_n - base), 3);
        reg_wr(3'd6, 32'd1);
        for (int i = 0; i < 2000 && !stat_block; i++) @(negedge clk);
        chk(wl_n - base == 6, "R6", "second reload block count", 32'(wl_n - base), 6);
        chk(wl_addr[base + 3] === 32'h2000 && wl_data[base + 5] === rd_pat(32'h1008), "R6",
            "reloaded addresses", wl_addr[base + 3], 32'h2000);
        reg_wr(3'd4, 32'h8);
        reg_wr(3'd6, 32'd1);
        for (int i = 0; i < 2000 && ch_en; i++) @(negedge clk);
        chk(wl_n - base == 9 && stat_xfer && stat_block, "R11", "end after reload cleared",
            32'(wl_n - base), 9);
        reg_wr(3'd6, 32'd3);

        // R12: abort in the middle of a block
        reg_wr(3'd0, 32'h3000); reg_wr(3'd1, 32'h4000); reg_wr(3'd2, 32'h0);
        reg_wr(3'd3, mkctl(40, 2, 2, 0, 0, 0, 0)); reg_wr(3'd4, 32'h0);
        base = wl_n;
        reg_wr(3'd5, 32'd1);
        for (int i = 0; i < 2000 && (wl_n - base) < 5; i++) @(negedge clk);
        reg_wr(3'd5, 32'd0);
        repeat (10) @(negedge clk);
        chk(!ch_en && !stat_xfer, "R12", "aborted channel idle, no done flag",
            {30'd0, ch_en, stat_xfer}, 0);
        c0 = wl_n;
        chk(wl_n - base < 40, "R12", "aborted before block end", 32'(wl_n - base), 39);
        repeat (30) @(negedge clk);
        chk(wl_n == c0, "R12", "no writes after abort", 32'(wl_n), 32'(c0));

        // R7: random linked chains with random reload subsets
        for (int t = 0; t < 24; t++) begin
            int nd;
            logic [3:0] cfg;
            nd = $urandom_range(0, 3);
            for (int j = 0; j < nd; j++) begin
                dmem[4 * (j + 1)]     = 32'h1_0000 + 32'($urandom_range(0, 255)) * 4;
                dmem[4 * (j + 1) + 1] = 32'h2_0000 + 32'($urandom_range(0, 255)) * 4;
                dmem[4 * (j + 1) + 2] = (j < nd - 1) ? 32'(16 * (j + 2)) : 32'h0;
                dmem[4 * (j + 1) + 3] = mkctl($urandom_range(1, 4), 2'($urandom_range(0, 2)),
                    2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end
            cfg = 4'($urandom_range(0, 15));
            if (cfg[2:0] == 3'b111) cfg[2] = 1'b0;
            do_case("R7", cfg, 32'h3_0000 + 32'($urandom_range(0, 255)) * 4,
                    32'h4_0000 + 32'($urandom_range(0, 255)) * 4,
                    (nd > 0) ? 32'h10 : 32'h0,
                    mkctl($urandom_range(1, 4), 2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)),
                          2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))), base);
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule